// File: doc/BRIEF.md
# Ordered Bus Protection Sequencer

This block fences or releases the bus interfaces of a power domain by walking a small table of protection entries, one at a time. Each entry carries a request mask, a status mask and a four-bit flag field. For every entry it acts on, the sequencer writes a protect or release action toward the protection logic. It then holds on that entry until the matching status acknowledge arrives, and only after that does it move to the next entry.

A single-cycle request starts a walk. The direction input selects fencing, which is done before a domain is powered down, or releasing, which is done after it is powered up. Fencing walks the table from index 0 upward. Releasing walks it from the top index downward. The per-entry flags do four things: they swap the action polarity, they let a release finish without waiting for status, they choose between a held protect level and one-cycle set/clear strobes, and they pick the status level that counts as released.

If an entry does not acknowledge within a programmable number of clock cycles, the walk is abandoned. The block then reports done together with a timeout error.

Top module: `bus_prot_seq`

## Requirements
- R1: After reset, every `protLevel` bit, both strobe buses, `busy`, `done` and `timeoutErr` are 0.
- R2: A fence walk (`reqFence`=1) visits entries 0, 1, 2 and so on in increasing order. It ends without acting at the first entry whose request mask is zero, and later entries are left untouched.
- R3: A release walk (`reqFence`=0) visits entries from index N-1 down to 0. Entries with a zero request mask are passed over, and the walk continues with the next lower index.
- R4: A protect action completes only once every bit of the entry's status mask reads 1 in that entry's `staIn` slice. A partial acknowledge keeps the walk waiting.
- R5: A release action completes when the masked status is zero. If flag bit 3 (release-high) is set, it instead completes when the masked status equals the full status mask.
- R6: Flag bit 0 (inverted) swaps the actions. Fencing then performs a release action, and releasing performs a protect action.
- R7: Flag bit 1 (no-ack) lets a release action finish one cycle after it is issued, whatever the status. Protect actions still wait.
- R8: Flag bit 2 selects the write style. When it is 1, the entry's `protLevel` slice has its mask bits set on protect and cleared on release, and no other bits change. When it is 0, the mask appears for exactly one cycle on the entry's `setStrobe` or `clrStrobe` slice, and `protLevel` is unchanged.
- R9: An entry that waits TIMEOUT cycles without its acknowledge aborts the walk. `done` then pulses with `timeoutErr`=1, and no later entry is acted on. `timeoutErr` holds until the next accepted request clears it.
- R10: A request that arrives while a walk is in progress, or in the cycle `done` is high, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| req | input | 1 | One-cycle walk request |
| reqFence | input | 1 | 1 = fence walk, 0 = release walk |
| entryMask | input | N*W | Request mask of each entry, entry i at bits [i*W +: W] |
| entryStaMask | input | N*W | Status mask of each entry |
| entryFlags | input | N*4 | Flags of each entry: bit0 inverted, bit1 no-ack, bit2 level style, bit3 release-high |
| staIn | input | N*W | Acknowledge status of each entry |
| protLevel | output | N*W | Held protect bits of level-style entries |
| setStrobe | output | N*W | One-cycle protect mask of strobe-style entries |
| clrStrobe | output | N*W | One-cycle release mask of strobe-style entries |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| timeoutErr | output | 1 | Last walk aborted on a missing acknowledge |

## Verification
The bench builds the block with four entries of eight bits and TIMEOUT set to 16. With that small timeout, the abort path and the wrong-level release cases each finish within a few dozen cycles. With four entries, one table can hold a zero-mask entry in the middle, so the stop-on-fence and skip-on-release behaviour can both be seen. A bench model of the protected fabric answers each entry from its level or strobe history. The model can freeze any entry's status at a chosen value, which makes it possible to reach partial acknowledges, wrong release levels and status that a no-ack entry must not wait on.

// File: rtl/bp_seq_pkg.sv
package bp_seq_pkg;
  localparam int FLAG_W     = 4;
  localparam int FLAG_INV   = 0;
  localparam int FLAG_NOACK = 1;
  localparam int FLAG_LEVEL = 2;
  localparam int FLAG_RELHI = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FIN
  } seqState_t;

  typedef struct packed {
    logic issue;
    logic actSet;
    logic errSet;
    logic errClr;
  } bpStrobe_t;
endpackage

// File: rtl/bp_seq_ctrl.sv
module bp_seq_ctrl
  import bp_seq_pkg::*;
#(
  parameter int N       = 4,
  parameter int TIMEOUT = 1024,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          req,
  input  logic          reqFence,
  input  logic          zeroMask,
  input  logic          invFlag,
  input  logic          noAck,
  input  logic          setMet,
  input  logic          clrMet,
  output logic [IW-1:0] idx,
  output bpStrobe_t     strb,
  output logic          busy,
  output logic          done
);
  seqState_t state, stateD;
  logic [IW-1:0] idxD;
  logic [CW-1:0] cnt, cntD;
  logic fence, fenceD;
  logic actQ, actD;
  logic lastIdx;
  logic [IW-1:0] stepIdx;
  logic met;

  assign lastIdx = fence ? (idx == IW'(N - 1)) : (idx == '0);
  assign stepIdx = fence ? idx + IW'(1) : idx - IW'(1);
  assign met     = (!actQ && noAck) || (actQ ? setMet : clrMet);

  always_comb begin
    stateD = state;
    idxD   = idx;
    cntD   = cnt;
    fenceD = fence;
    actD   = actQ;
    strb   = '0;
    unique case (state)
      ST_IDLE: begin
        if (req) begin
          fenceD      = reqFence;
          idxD        = reqFence ? '0 : IW'(N - 1);
          strb.errClr = 1'b1;
          stateD      = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (zeroMask) begin
          if (fence || lastIdx) stateD = ST_FIN;
          else                  idxD   = stepIdx;
        end else begin
          strb.issue  = 1'b1;
          strb.actSet = fence ^ invFlag;
          actD        = fence ^ invFlag;
          cntD        = '0;
          stateD      = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (met) begin
          if (lastIdx) stateD = ST_FIN;
          else begin
            idxD   = stepIdx;
            stateD = ST_ISSUE;
          end
        end else if (cnt == CW'(TIMEOUT - 1)) begin
          strb.errSet = 1'b1;
          stateD      = ST_FIN;
        end else begin
          cntD = cnt + CW'(1);
        end
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      cnt   <= '0;
      fence <= 1'b0;
      actQ  <= 1'b0;
    end else begin
      state <= stateD;
      idx   <= idxD;
      cnt   <= cntD;
      fence <= fenceD;
      actQ  <= actD;
    end
  end

  assign busy = (state == ST_ISSUE) || (state == ST_WAIT);
  assign done = (state == ST_FIN);
endmodule

// File: rtl/bp_seq_dpath.sv
module bp_seq_dpath
  import bp_seq_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IW-1:0]     idx,
  input  bpStrobe_t         strb,
  input  logic [N*W-1:0]    entryMask,
  input  logic [N*W-1:0]    entryStaMask,
  input  logic [N*FLAG_W-1:0] entryFlags,
  input  logic [N*W-1:0]    staIn,
  output logic              zeroMask,
  output logic              invFlag,
  output logic              noAck,
  output logic              setMet,
  output logic              clrMet,
  output logic [N*W-1:0]    protLevel,
  output logic [N*W-1:0]    setStrobe,
  output logic [N*W-1:0]    clrStrobe,
  output logic              timeoutErr
);
  logic [W-1:0]      curMask, curSta, curStaMask, relLevel;
  logic [FLAG_W-1:0] curFlags;

  assign curMask    = entryMask[idx*W +: W];
  assign curStaMask = entryStaMask[idx*W +: W];
  assign curSta     = staIn[idx*W +: W] & curStaMask;
  assign curFlags   = entryFlags[idx*FLAG_W +: FLAG_W];
  assign relLevel   = curFlags[FLAG_RELHI] ? curStaMask : '0;

  assign zeroMask = (curMask == '0);
  assign invFlag  = curFlags[FLAG_INV];
  assign noAck    = curFlags[FLAG_NOACK];
  assign setMet   = (curSta == curStaMask);
  assign clrMet   = (curSta == relLevel);

  for (genvar i = 0; i < N; i++) begin : g_entry
    logic hit, lvlStyle;
    logic [W-1:0] m;
    assign hit      = strb.issue && (idx == IW'(i));
    assign lvlStyle = entryFlags[i*FLAG_W + FLAG_LEVEL];
    assign m        = entryMask[i*W +: W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        protLevel[i*W +: W] <= '0;
        setStrobe[i*W +: W] <= '0;
        clrStrobe[i*W +: W] <= '0;
      end else begin
        setStrobe[i*W +: W] <= (hit && !lvlStyle && strb.actSet)  ? m : '0;
        clrStrobe[i*W +: W] <= (hit && !lvlStyle && !strb.actSet) ? m : '0;
        if (hit && lvlStyle) begin
          if (strb.actSet) protLevel[i*W +: W] <= protLevel[i*W +: W] | m;
          else             protLevel[i*W +: W] <= protLevel[i*W +: W] & ~m;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            timeoutErr <= 1'b0;
    else if (strb.errClr) timeoutErr <= 1'b0;
    else if (strb.errSet) timeoutErr <= 1'b1;
  end
endmodule

// File: rtl/bus_prot_seq.sv
module bus_prot_seq
  import bp_seq_pkg::*;
#(
  parameter int N       = 4,
  parameter int W       = 8,
  parameter int TIMEOUT = 1024,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                req,
  input  logic                reqFence,
  input  logic [N*W-1:0]      entryMask,
  input  logic [N*W-1:0]      entryStaMask,
  input  logic [N*FLAG_W-1:0] entryFlags,
  input  logic [N*W-1:0]      staIn,
  output logic [N*W-1:0]      protLevel,
  output logic [N*W-1:0]      setStrobe,
  output logic [N*W-1:0]      clrStrobe,
  output logic                busy,
  output logic                done,
  output logic                timeoutErr
);
  logic [IW-1:0] idx;
  bpStrobe_t strb;
  logic zeroMask, invFlag, noAck, setMet, clrMet;

  bp_seq_ctrl #(.N(N), .TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .reqFence(reqFence),
    .zeroMask(zeroMask), .invFlag(invFlag), .noAck(noAck),
    .setMet(setMet), .clrMet(clrMet),
    .idx(idx), .strb(strb), .busy(busy), .done(done)
  );

  bp_seq_dpath #(.N(N), .W(W)) u_dpath (
    .clk(clk), .rstN(rstN), .idx(idx), .strb(strb),
    .entryMask(entryMask), .entryStaMask(entryStaMask),
    .entryFlags(entryFlags), .staIn(staIn),
    .zeroMask(zeroMask), .invFlag(invFlag), .noAck(noAck),
    .setMet(setMet), .clrMet(clrMet),
    .protLevel(protLevel), .setStrobe(setStrobe), .clrStrobe(clrStrobe),
    .timeoutErr(timeoutErr)
  );
endmodule

// File: rtl/bus_prot_seq_chk.sv
module bus_prot_seq_chk #(
  parameter int N = 4,
  parameter int W = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           busy,
  input logic           done,
  input logic           timeoutErr,
  input logic [N*W-1:0] protLevel,
  input logic [N*W-1:0] setStrobe,
  input logic [N*W-1:0] clrStrobe
);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> done);

  assert_walk_end_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> $stable(protLevel));

  assert_strobe_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((|setStrobe) || (|clrStrobe)) |-> busy);
endmodule

bind bus_prot_seq bus_prot_seq_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .timeoutErr(timeoutErr),
  .protLevel(protLevel), .setStrobe(setStrobe), .clrStrobe(clrStrobe)
);

// File: tb/bus_prot_seq_tb.sv
module bus_prot_seq_tb;
  localparam int N = 4;
  localparam int W = 8;
  localparam int TO = 16;
  localparam logic [3:0] F_INV = 4'h1, F_NOACK = 4'h2, F_LVL = 4'h4, F_RELHI = 4'h8;

  logic clk = 0, rstN = 0, req = 0, reqFence = 0;
  logic [N*W-1:0] entryMask = '0, entryStaMask = '0, staIn = '0;
  logic [N*4-1:0] entryFlags = '0;
  logic [N*W-1:0] protLevel, setStrobe, clrStrobe;
  logic busy, done, timeoutErr;

  int errors = 0, checks = 0, cyc = 0;
  logic [N-1:0] freeze = '0;
  logic [W-1:0] forced [N];
  logic [W-1:0] dirSt [N];
  logic [W-1:0] prevLvl [N];
  int setCnt [N], clrCnt [N];
  logic [31:0] order = 0;

  always #4 clk = ~clk;

  bus_prot_seq #(.N(N), .W(W), .TIMEOUT(TO)) u_dut (
    .clk(clk), .rstN(rstN), .req(req), .reqFence(reqFence),
    .entryMask(entryMask), .entryStaMask(entryStaMask), .entryFlags(entryFlags),
    .staIn(staIn), .protLevel(protLevel), .setStrobe(setStrobe),
    .clrStrobe(clrStrobe), .busy(busy), .done(done), .timeoutErr(timeoutErr)
  );

  // model of the protected fabric: answers one cycle after a change
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      logic prot;
      if (!rstN) dirSt[i] <= '0;
      else dirSt[i] <= (dirSt[i] | setStrobe[i*W +: W]) & ~clrStrobe[i*W +: W];
      prot = entryFlags[i*4 + 2] ? (protLevel[i*W +: W] != 0) : (dirSt[i] != 0);
      if (freeze[i]) staIn[i*W +: W] <= forced[i];
      else staIn[i*W +: W] <= (prot || entryFlags[i*4 + 3]) ? {W{1'b1}} : '0;
    end
  end

  // action log, sampled away from the edge
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (protLevel[i*W +: W] != prevLvl[i] || setStrobe[i*W +: W] != 0 || clrStrobe[i*W +: W] != 0)
        order = (order << 4) | (i + 1);
      if (setStrobe[i*W +: W] != 0) setCnt[i]++;
      if (clrStrobe[i*W +: W] != 0) clrCnt[i]++;
      prevLvl[i] = protLevel[i*W +: W];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setEntry(input int i, input logic [W-1:0] m, input logic [W-1:0] s, input logic [3:0] f);
    entryMask[i*W +: W] = m;
    entryStaMask[i*W +: W] = s;
    entryFlags[i*4 +: 4] = f;
  endtask

  task automatic clearLog();
    order = 0;
    for (int i = 0; i < N; i++) begin setCnt[i] = 0; clrCnt[i] = 0; end
  endtask

  task automatic applyReset();
    @(negedge clk); rstN = 0; freeze = '0;
    entryMask = '0; entryStaMask = '0; entryFlags = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic runReq(input logic f);
    clearLog();
    @(negedge clk); req = 1; reqFence = f;
    @(negedge clk); req = 0;
    cyc = 1;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    if (!done) chk("watchdog no done", 0, 1);
  endtask

  task automatic allLevel();
    setEntry(0, 8'h0F, 8'h03, F_LVL);
    setEntry(1, 8'hF0, 8'h0C, F_LVL);
    setEntry(2, 8'h3C, 8'hFF, F_LVL);
    setEntry(3, 8'h81, 8'h01, F_LVL);
  endtask

  task automatic t_reset();
    applyReset();
    chk("R1 level", protLevel, 0);
    chk("R1 strobes", setStrobe | clrStrobe, 0);
    chk("R1 flags", {busy, done, timeoutErr}, 0);
  endtask

  task automatic t_fenceOrder();
    applyReset(); allLevel();
    runReq(1);
    chk("R2 order", order, 32'h1234);
    chk("R8 level mask bits only", protLevel, 32'h813CF00F);
    chk("R2 no err", timeoutErr, 0);
  endtask

  task automatic t_fenceStop();
    applyReset(); allLevel(); setEntry(2, 8'h00, 8'hFF, F_LVL);
    runReq(1);
    chk("R2 stop at zero", order, 32'h12);
    chk("R2 entry3 untouched", protLevel[3*W +: W], 0);
  endtask

  task automatic t_releaseOrder();
    applyReset(); allLevel();
    runReq(1);
    entryMask[1*W +: W] = 8'h00;
    runReq(0);
    chk("R3 reverse skip", order, 32'h431);
    chk("R3 entry1 kept", protLevel[1*W +: W], 8'hF0);
    chk("R3 others released", {protLevel[3*W +: W], protLevel[2*W +: W], protLevel[0 +: W]}, 0);
    chk("R3 no err", timeoutErr, 0);
  endtask

  task automatic t_inverted();
    applyReset(); setEntry(0, 8'h55, 8'hFF, F_INV);
    runReq(1);
    chk("R6 fence clears", {setCnt[0][7:0], clrCnt[0][7:0]}, 16'h0001);
    chk("R8 strobe style level untouched", protLevel, 0);
    runReq(0);
    chk("R6 release sets", {setCnt[0][7:0], clrCnt[0][7:0]}, 16'h0100);
    chk("R6 no err", timeoutErr, 0);
  endtask

  task automatic t_noAck();
    applyReset(); setEntry(0, 8'h11, 8'hFF, F_INV | F_NOACK);
    freeze[0] = 1; forced[0] = 8'hFF;
    runReq(1);
    chk("R7 clear without ack", timeoutErr, 0);
    chk("R7 quick finish", (cyc < 8) ? 1 : 0, 1);
    runReq(0);
    chk("R7 set still ack ok", timeoutErr, 0);
    entryFlags[3:0] = F_INV;
    runReq(1);
    chk("R7 clear waits without flag", timeoutErr, 1);
  endtask

  task automatic t_release();
    applyReset(); setEntry(0, 8'h03, 8'h0F, F_LVL | F_RELHI);
    runReq(1); runReq(0);
    chk("R5 release-high met", timeoutErr, 0);
    runReq(1);
    freeze[0] = 1; forced[0] = 8'h00;
    runReq(0);
    chk("R5 release-high zero fails", timeoutErr, 1);
    freeze[0] = 0;
    entryFlags[3:0] = F_LVL;
    runReq(1);
    freeze[0] = 1; forced[0] = 8'hFF;
    runReq(0);
    chk("R5 release expects zero", timeoutErr, 1);
  endtask

  task automatic t_timeout();
    applyReset(); allLevel();
    freeze[1] = 1; forced[1] = 8'h04;
    runReq(1);
    chk("R4 partial ack times out", timeoutErr, 1);
    chk("R9 waited timeout", (cyc >= TO) ? 1 : 0, 1);
    chk("R9 abort later entries", {protLevel[3*W +: W], protLevel[2*W +: W]}, 0);
    chk("R9 order", order, 32'h12);
    freeze[1] = 0;
    runReq(1);
    chk("R9 err cleared on new walk", timeoutErr, 0);
    chk("R4 full ack finishes", protLevel, 32'h813CF00F);
  endtask

  task automatic t_busyReq();
    applyReset(); allLevel();
    clearLog();
    @(negedge clk); req = 1; reqFence = 1;
    @(negedge clk); req = 0;
    repeat (3) @(negedge clk);
    req = 1; reqFence = 0;
    @(negedge clk); req = 0;
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    req = 1; reqFence = 0;
    @(negedge clk); req = 0;
    repeat (4) @(negedge clk);
    chk("R10 busy req ignored", protLevel, 32'h813CF00F);
    chk("R10 no restart", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin forced[i] = '0; prevLvl[i] = '0; end
    clearLog();
    t_reset();
    t_fenceOrder();
    t_fenceStop();
    t_releaseOrder();
    t_inverted();
    t_noAck();
    t_release();
    t_timeout();
    t_busyReq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule